// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Select

This block sits in front of the ALU in the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it decides whether the value read from the register file during decode is still current. If it is not, the block substitutes a result that a younger-but-older instruction has already computed, and it does this without waiting for that result to reach the register file. Two candidate results exist. The first is the ALU result held in the execute/memory pipeline register, one instruction ahead. The second is the write-back value held in the memory/write-back pipeline register, two instructions ahead.

The block is purely combinational and has no internal state. Each operand lane compares its source register number with the destination register numbers of the two later stages. A stage only counts when its write-enable flag is set and its destination is not register 0. Each lane outputs a 2-bit select code and the chosen operand. The memory-stage candidate wins when both stages match, because it carries the more recent value. Stall generation and bypassing of store data are handled elsewhere.

Top module: `exu_operand_bypass`

## Requirements
- R1: When neither later stage qualifies for a lane, that lane's select code is 2'b00 and its operand equals the register-file value for that lane.
- R2: When the execute/memory stage has its write enable set, a nonzero destination, and a destination equal to a lane's source register, that lane's select code is 2'b10 and its operand equals the execute/memory ALU result.
- R3: When only the memory/write-back stage has its write enable set, a nonzero destination, and a destination equal to a lane's source register, that lane's select code is 2'b01 and its operand equals the write-back data.
- R4: When both stages qualify for the same lane, the execute/memory stage wins: select code 2'b10, operand equals the ALU result.
- R5: A stage whose write enable is low never supplies an operand, even when its destination matches the source register.
- R6: A stage whose destination is register 0 never supplies an operand, even when its write enable is set and the source register is also 0. The lane then passes the register-file value with select 2'b00.
- R7: The two lanes decide independently. Lane A compares against the first source register and lane B against the second, so one lane may bypass while the other does not, or the two may take different stages.
- R8: The select code 2'b11 is never produced on either lane.
- R9: Outputs depend only on the present inputs and follow an input change within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| rf_a | input | 32 | Register-file value read for src_a during decode |
| rf_b | input | 32 | Register-file value read for src_b during decode |
| exm_dst | input | 5 | Destination register number held in the execute/memory register |
| exm_wen | input | 1 | Register write enable held in the execute/memory register |
| exm_result | input | 32 | ALU result held in the execute/memory register |
| mwb_dst | input | 5 | Destination register number held in the memory/write-back register |
| mwb_wen | input | 1 | Register write enable held in the memory/write-back register |
| mwb_data | input | 32 | Write-back data held in the memory/write-back register |
| sel_a | output | 2 | Lane A select: 00 register file, 10 execute/memory, 01 memory/write-back |
| sel_b | output | 2 | Lane B select, same encoding as sel_a |
| opnd_a | output | 32 | Selected first ALU operand |
| opnd_b | output | 32 | Selected second ALU operand |

## Verification
The bench targets the double-match case with different data in each stage. A design with the wrong priority returns the older write-back data there. It also drives register 0 as both source and destination with write enable set. A design missing the zero guard would forward a nonzero ALU result into a read of the constant-zero register. A matching destination with write enable low catches a design that ignores the enable. Mixed cases, where lane A bypasses while lane B does not, catch crossed comparisons between the source fields. A long run of random vectors drawn from a small register range then exercises all of these combinations.

// File: rtl/exu_operand_bypass.sv
module exu_operand_bypass #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic              exm_wen,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic              mwb_wen,
  input  logic [DATA_W-1:0] mwb_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [1:0] SEL_EXM = 2'b10;

  logic exm_live, mwb_live;
  assign exm_live = exm_wen && (exm_dst != '0);
  assign mwb_live = mwb_wen && (mwb_dst != '0);

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src);
    if (exm_live && exm_dst == src)      return SEL_EXM;
    else if (mwb_live && mwb_dst == src) return SEL_MWB;
    else                                 return SEL_RF;
  endfunction

  function automatic logic [DATA_W-1:0] route(input logic [1:0] sel,
                                              input logic [DATA_W-1:0] rf);
    case (sel)
      SEL_EXM: return exm_result;
      SEL_MWB: return mwb_data;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(src_a);
  assign sel_b  = pick(src_b);
  assign opnd_a = route(sel_a, rf_a);
  assign opnd_b = route(sel_b, rf_b);

endmodule

// File: rtl/exu_operand_bypass_chk.sv
module exu_operand_bypass_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  src_b,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [REG_W-1:0]  exm_dst,
  input logic              exm_wen,
  input logic [DATA_W-1:0] exm_result,
  input logic [REG_W-1:0]  mwb_dst,
  input logic              mwb_wen,
  input logic [DATA_W-1:0] mwb_data,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);

  logic known;
  assign known = !$isunknown({src_a, src_b, rf_a, rf_b, exm_dst, exm_wen,
                              exm_result, mwb_dst, mwb_wen, mwb_data});

  always_comb begin
    if (known) begin
      assert_no_code3_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);
      assert_rf_pass_a_R1: assert (sel_a != 2'b00 || opnd_a == rf_a);
      assert_rf_pass_b_R1: assert (sel_b != 2'b00 || opnd_b == rf_b);
      assert_exm_data_R2: assert ((sel_a != 2'b10 || opnd_a == exm_result) &&
                                  (sel_b != 2'b10 || opnd_b == exm_result));
      assert_mwb_data_R3: assert ((sel_a != 2'b01 || opnd_a == mwb_data) &&
                                  (sel_b != 2'b01 || opnd_b == mwb_data));
      assert_exm_wins_R4: assert (!(exm_wen && exm_dst != 0 && exm_dst == src_a) ||
                                  sel_a == 2'b10);
      assert_no_dead_src_R5: assert ((exm_wen || (sel_a != 2'b10 && sel_b != 2'b10)) &&
                                     (mwb_wen || (sel_a != 2'b01 && sel_b != 2'b01)));
      assert_zero_reg_R6: assert ((src_a != 0 || sel_a == 2'b00) &&
                                  (src_b != 0 || sel_b == 2'b00));
    end
  end

endmodule

bind exu_operand_bypass exu_operand_bypass_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
  .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_result(exm_result),
  .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_data(mwb_data),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/test_exu_operand_bypass.sv
module test_exu_operand_bypass;

  logic clk = 0;
  always #2 clk = ~clk;

  logic [4:0]  src_a = 0, src_b = 0, exm_dst = 0, mwb_dst = 0;
  logic [31:0] rf_a = 0, rf_b = 0, exm_result = 0, mwb_data = 0;
  logic        exm_wen = 0, mwb_wen = 0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  exu_operand_bypass i_exu_operand_bypass (
    .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
    .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_result(exm_result),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_data(mwb_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    logic [1:0]  sa, sb;
    logic [31:0] oa, ob;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int vectors = 0, errs = 0;
  bit done = 0;

  function automatic logic [1:0] model_sel(input logic [4:0] src, input logic [4:0] ed,
                                           input logic ew, input logic [4:0] md, input logic mw);
    logic [1:0] s;
    s = 2'b00;
    if (mw && md != 5'd0 && md == src) s = 2'b01;
    if (ew && ed != 5'd0 && ed == src) s = 2'b10;
    return s;
  endfunction

  function automatic logic [31:0] model_val(input logic [1:0] s, input logic [31:0] rf,
                                            input logic [31:0] er, input logic [31:0] wd);
    if (s == 2'b10) return er;
    if (s == 2'b01) return wd;
    return rf;
  endfunction

  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [31:0] ra, input logic [31:0] rb,
                       input logic [4:0] ed, input logic ew, input logic [31:0] er,
                       input logic [4:0] md, input logic mw, input logic [31:0] wd,
                       input string tag);
    item_t it;
    @(posedge clk); #1;
    src_a = sa; src_b = sb; rf_a = ra; rf_b = rb;
    exm_dst = ed; exm_wen = ew; exm_result = er;
    mwb_dst = md; mwb_wen = mw; mwb_data = wd;
    it.sa = model_sel(sa, ed, ew, md, mw);
    it.sb = model_sel(sb, ed, ew, md, mw);
    it.oa = model_val(it.sa, ra, er, wd);
    it.ob = model_val(it.sb, rb, er, wd);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        vectors++;
        if (sel_a !== it.sa) begin errs++; $display("FAIL %s sel_a got %b exp %b", it.tag, sel_a, it.sa); end
        if (sel_b !== it.sb) begin errs++; $display("FAIL %s sel_b got %b exp %b", it.tag, sel_b, it.sb); end
        if (opnd_a !== it.oa) begin errs++; $display("FAIL %s opnd_a got %h exp %h", it.tag, opnd_a, it.oa); end
        if (opnd_b !== it.ob) begin errs++; $display("FAIL %s opnd_b got %h exp %h", it.tag, opnd_b, it.ob); end
        if (sel_a == 2'b11 || sel_b == 2'b11) begin
          errs++; $display("FAIL R8 code 11 seen got %b/%b exp not 11", sel_a, sel_b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin : driver
    // idle state: all zero, no bypass (R1)
    apply(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 0, 0, 32'h0, "R1 idle");
    apply(3, 4, 32'hA0A0_0001, 32'hB0B0_0002, 7, 1, 32'hEEEE_0001, 9, 1, 32'hDDDD_0001, "R1 no match");
    apply(5, 6, 32'h1, 32'h2, 5, 1, 32'hCAFE_0005, 0, 0, 32'h0, "R2 exm lane A");
    apply(5, 6, 32'h1, 32'h2, 6, 1, 32'hCAFE_0006, 0, 0, 32'h0, "R2 exm lane B");
    apply(8, 2, 32'h1, 32'h2, 0, 0, 32'h0, 8, 1, 32'hBEEF_0008, "R3 mwb lane A");
    apply(8, 2, 32'h1, 32'h2, 3, 1, 32'h3, 2, 1, 32'hBEEF_0002, "R3 mwb lane B");
    apply(11, 11, 32'h1, 32'h2, 11, 1, 32'h1111_1111, 11, 1, 32'h2222_2222, "R4 both stages");
    apply(12, 13, 32'h1, 32'h2, 12, 0, 32'hDEAD_0001, 13, 0, 32'hDEAD_0002, "R5 wen low");
    apply(14, 14, 32'h5, 32'h6, 14, 0, 32'hDEAD_0003, 14, 1, 32'h7777_0000, "R5 exm off mwb on");
    apply(0, 0, 32'h0, 32'h0, 0, 1, 32'hFFFF_FFFF, 0, 1, 32'hAAAA_AAAA, "R6 zero reg");
    apply(0, 9, 32'h0, 32'h9, 0, 1, 32'h1234_5678, 9, 1, 32'h9999_9999, "R6 zero lane A");
    apply(4, 7, 32'h4, 32'h7, 7, 1, 32'h7070_7070, 4, 1, 32'h4040_4040, "R7 crossed lanes");
    apply(4, 4, 32'h4, 32'h44, 4, 1, 32'hABCD_0004, 0, 1, 32'h0, "R7 same src both");
    apply(1, 2, 32'h10, 32'h20, 1, 1, 32'h3, 2, 1, 32'h4, "R9 change 1");
    apply(2, 1, 32'h10, 32'h20, 1, 1, 32'h3, 2, 1, 32'h4, "R9 change 2");
    for (int i = 0; i < 600; i++) begin
      apply(5'($urandom_range(3)), 5'($urandom_range(3)), $urandom, $urandom,
            5'($urandom_range(3)), 1'($urandom_range(1)), $urandom,
            5'($urandom_range(3)), 1'($urandom_range(1)), $urandom, "R7 random");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule